// File: doc/BRIEF.md
# CAN Error Counter and Error Interrupt Tracker

This block keeps the fault-confinement bookkeeping of a CAN node. The protocol engine reports one event per frame: whether the frame succeeded, whether the node was transmitting or receiving, and a 3-bit error type when the frame failed. From these events the block keeps an 8-bit transmit error count and an 8-bit receive error count. It derives three state flags from the counts: warning, passive and bus-off. It also holds a sticky last-error code.

Software sees everything through one 32-bit status word. Software may load the last-error code field, for example with the value 7, so that a later read shows whether any bus event has replaced it. A single pending flag collects the enabled error sources behind a global enable. Software clears that flag by writing one. A recovery input returns the counters and the bus-off flag to zero. The rest of the bus-off recovery sequence belongs to the surrounding controller.

Top module: `can_err_tracker`

## Requirements
- R1: After reset the status word reads zero and the pending flag is low.
- R2: A failed transmit frame adds 8 to the transmit count. A failed receive frame adds 1 to the receive count, and the receive count stops at 255.
- R3: A successful frame lowers the count of its own direction by 1, stopping at 0, and leaves the other count unchanged.
- R4: Warning (status bit 0) is high while either count is 96 or more. Passive (status bit 1) is high while either count is above 127.
- R5: A failed transmit frame that would take the transmit count past 255 sets bus-off (status bit 2) and leaves the count at 255. Bus-off holds, and frame events have no effect on the counts or on the last-error code while it is set.
- R6: A recovery pulse clears both counts and bus-off.
- R7: The last-error code sits in status bits 6:4 with the encoding 0 none, 1 stuff, 2 form, 3 acknowledge, 4 recessive bit, 5 dominant bit, 6 CRC, 7 unused. A failed frame records its type there, and a successful frame records 0.
- R8: A software write loads the last-error code. A later frame event replaces it. If a frame event and a software write fall in the same cycle, the frame event wins.
- R9: The receive count sits in status bits 31:24 and the transmit count in bits 23:16. Bits 15:7 and bit 3 read zero.
- R10: When the global enable is high, the pending flag sets in the cycle after either of two causes. One cause is a change of warning, passive or bus-off whose own enable is high. The other is a failed frame that records a nonzero code while the code enable is high.
- R11: The pending flag does not set when the global enable is low, or when the enable of the cause is low.
- R12: A write-one-to-clear pulse drops the pending flag. If a new cause arrives in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | One frame event this cycle |
| ev_tx | input | 1 | 1 = node was transmitter, 0 = receiver |
| ev_ok | input | 1 | 1 = frame succeeded |
| ev_code | input | 3 | Error type for a failed frame (R7 encoding) |
| recover | input | 1 | Clears both counts and bus-off |
| lec_we | input | 1 | Software write strobe for the last-error code |
| lec_wdata | input | 3 | Value to load into the last-error code |
| pend_w1c | input | 1 | Write-one pulse clearing the pending flag |
| en_glob | input | 1 | Global error interrupt enable |
| en_lec | input | 1 | Enable for recorded nonzero error codes |
| en_boff | input | 1 | Enable for bus-off changes |
| en_pasv | input | 1 | Enable for passive changes |
| en_warn | input | 1 | Enable for warning changes |
| status | output | 32 | Error status word (R9, R4, R5, R7 layout) |
| err_pending | output | 1 | Pending error interrupt flag and request |

## Verification
Two pairs of operations can land on the same edge. The first pair is a write-one clear of the pending flag and a failed frame whose code is enabled. The second pair is a software load of the last-error code and a frame event. The bench drives both members of each pair in one cycle. It expects the pending flag to stay high and the code to show the frame's error type rather than the software value. Threshold crossings are driven one frame at a time, so that the flags and the pending flag can be judged on the exact frame that crosses 96, 128 and 256.

// File: rtl/can_err_tracker.sv
module can_err_tracker #(
  parameter int unsigned WARN_AT  = 96,
  parameter int unsigned PASV_ABV = 127,
  parameter int unsigned TX_STEP  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_valid,
  input  logic        ev_tx,
  input  logic        ev_ok,
  input  logic [2:0]  ev_code,
  input  logic        recover,
  input  logic        lec_we,
  input  logic [2:0]  lec_wdata,
  input  logic        pend_w1c,
  input  logic        en_glob,
  input  logic        en_lec,
  input  logic        en_boff,
  input  logic        en_pasv,
  input  logic        en_warn,
  output logic [31:0] status,
  output logic        err_pending
);

  logic [7:0] tec, rec, tec_n, rec_n;
  logic [2:0] lec, lec_n;
  logic       boff, boff_n;
  logic [8:0] tec_sum;
  logic       ev_take, warn, pasv, warn_n, pasv_n, cause;

  assign ev_take = ev_valid && !boff && !recover;
  assign tec_sum = {1'b0, tec} + 9'(TX_STEP);

  always_comb begin
    tec_n  = tec;
    rec_n  = rec;
    boff_n = boff;
    lec_n  = lec_we ? lec_wdata : lec;
    if (recover) begin
      tec_n  = '0;
      rec_n  = '0;
      boff_n = 1'b0;
    end else if (ev_take) begin
      if (ev_ok) begin
        lec_n = 3'd0;
        if (ev_tx) tec_n = (tec == 8'd0) ? 8'd0 : tec - 8'd1;
        else       rec_n = (rec == 8'd0) ? 8'd0 : rec - 8'd1;
      end else begin
        lec_n = ev_code;
        if (ev_tx) begin
          if (tec_sum > 9'd255) begin
            tec_n  = 8'd255;
            boff_n = 1'b1;
          end else begin
            tec_n = tec_sum[7:0];
          end
        end else begin
          rec_n = (rec == 8'd255) ? 8'd255 : rec + 8'd1;
        end
      end
    end
  end

  assign warn   = (tec >= 8'(WARN_AT)) || (rec >= 8'(WARN_AT));
  assign pasv   = (tec > 8'(PASV_ABV)) || (rec > 8'(PASV_ABV));
  assign warn_n = (tec_n >= 8'(WARN_AT)) || (rec_n >= 8'(WARN_AT));
  assign pasv_n = (tec_n > 8'(PASV_ABV)) || (rec_n > 8'(PASV_ABV));

  assign cause = en_glob && ((en_warn && (warn_n != warn)) ||
                             (en_pasv && (pasv_n != pasv)) ||
                             (en_boff && (boff_n != boff)) ||
                             (en_lec && ev_take && !ev_ok && (ev_code != 3'd0)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec         <= '0;
      rec         <= '0;
      lec         <= '0;
      boff        <= 1'b0;
      err_pending <= 1'b0;
    end else begin
      tec         <= tec_n;
      rec         <= rec_n;
      lec         <= lec_n;
      boff        <= boff_n;
      err_pending <= cause ? 1'b1 : (pend_w1c ? 1'b0 : err_pending);
    end
  end

  assign status = {rec, tec, 9'd0, lec, 1'b0, boff, pasv, warn};

  // R2: a failed transmit frame below the ceiling steps the count by the fixed amount
  a_r2_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ok && ev_tx && !boff && !recover && (tec < 8'(256 - TX_STEP))
    |=> status[23:16] == $past(tec) + 8'(TX_STEP));

  // R3: the receive count only moves for receive events or recovery
  a_r3_rec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !recover && !(ev_valid && !ev_tx) |=> $stable(status[31:24]));

  // R5: bus-off is held until recovery
  a_r5_boff_hold: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] && !recover |=> status[2]);

  // R5: while bus-off, frame events leave the code untouched
  a_r5_lec_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] && !recover && !lec_we |=> $stable(status[6:4]));

  // R11: with the global enable low the pending flag cannot rise
  a_r11_glob_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !en_glob && !err_pending |=> !err_pending);

  // R12: a clear with no possible cause leaves the flag low
  a_r12_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    pend_w1c && !en_glob |=> !err_pending);

endmodule

// File: tb/can_err_tracker_tb.sv
module can_err_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 0, ev_tx = 0, ev_ok = 0;
  logic [2:0]  ev_code = 0;
  logic        recover = 0, lec_we = 0, pend_w1c = 0;
  logic [2:0]  lec_wdata = 0;
  logic        en_glob = 0, en_lec = 0, en_boff = 0, en_pasv = 0, en_warn = 0;
  logic [31:0] status;
  logic        err_pending;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  can_err_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_tx(ev_tx), .ev_ok(ev_ok),
    .ev_code(ev_code), .recover(recover), .lec_we(lec_we), .lec_wdata(lec_wdata),
    .pend_w1c(pend_w1c), .en_glob(en_glob), .en_lec(en_lec), .en_boff(en_boff),
    .en_pasv(en_pasv), .en_warn(en_warn), .status(status), .err_pending(err_pending)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ev(input logic tx, input logic ok, input logic [2:0] code);
    ev_valid = 1; ev_tx = tx; ev_ok = ok; ev_code = code;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic do_recover();
    recover = 1; pend_w1c = 1;
    @(negedge clk);
    recover = 0; pend_w1c = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 32'h0);
    chk("R1 pending", {31'd0, err_pending}, 32'd0);
  endtask

  task automatic t_counts();
    ev(1, 0, 3'd1);
    chk("R2 tec+8", {24'd0, status[23:16]}, 32'd8);
    chk("R7 stuff code", {29'd0, status[6:4]}, 32'd1);
    ev(0, 0, 3'd2);
    chk("R9 full word", status, {8'd1, 8'd8, 9'd0, 3'd2, 4'd0});
    ev(1, 1, 3'd0);
    chk("R3 tec-1", {24'd0, status[23:16]}, 32'd7);
    chk("R3 rec kept", {24'd0, status[31:24]}, 32'd1);
    chk("R7 ok clears", {29'd0, status[6:4]}, 32'd0);
    ev(0, 1, 3'd0);
    ev(0, 1, 3'd0);
    chk("R3 rec floor", {24'd0, status[31:24]}, 32'd0);
    for (int i = 0; i < 260; i++) ev(0, 0, 3'd6);
    chk("R2 rec ceiling", {24'd0, status[31:24]}, 32'd255);
    chk("R4 flags by rec", {29'd0, status[2:0]}, 32'd3);
    do_recover();
    chk("R6 clear", {status[31:16], 13'd0, status[2:0]}, 32'd0);
  endtask

  task automatic t_flags();
    do_recover();
    for (int i = 0; i < 11; i++) ev(1, 0, 3'd3);
    chk("R4 88 no warn", {29'd0, status[2:0]}, 32'd0);
    ev(1, 0, 3'd3);
    chk("R4 96 warn", {29'd0, status[2:0]}, 32'd1);
    for (int i = 0; i < 3; i++) ev(1, 0, 3'd3);
    chk("R4 120 not passive", {29'd0, status[2:0]}, 32'd1);
    ev(1, 0, 3'd3);
    chk("R4 128 passive", {29'd0, status[2:0]}, 32'd3);
    for (int i = 0; i < 15; i++) ev(1, 0, 3'd3);
    chk("R5 248 no boff", {21'd0, status[23:16], status[2:0]}, {21'd0, 8'd248, 3'd3});
    ev(1, 0, 3'd5);
    chk("R5 boff set", {21'd0, status[23:16], status[2:0]}, {21'd0, 8'd255, 3'd7});
    ev(0, 0, 3'd2);
    ev(1, 1, 3'd0);
    chk("R5 events ignored", status, {8'd0, 8'd255, 9'd0, 3'd5, 4'd7});
    do_recover();
    chk("R6 after boff", {status[31:16], 13'd0, status[2:0]}, 32'd0);
  endtask

  task automatic t_lec_sw();
    lec_we = 1; lec_wdata = 3'd7;
    @(negedge clk);
    lec_we = 0;
    chk("R8 sw load", {29'd0, status[6:4]}, 32'd7);
    ev(0, 1, 3'd0);
    chk("R8 event replaces", {29'd0, status[6:4]}, 32'd0);
    lec_we = 1; lec_wdata = 3'd7;
    ev(0, 0, 3'd3);
    lec_we = 0;
    chk("R8 event wins", {29'd0, status[6:4]}, 32'd3);
    do_recover();
  endtask

  task automatic t_irq();
    do_recover();
    en_glob = 1; en_lec = 1;
    ev(0, 0, 3'd6);
    chk("R10 code cause", {31'd0, err_pending}, 32'd1);
    pend_w1c = 1; @(negedge clk); pend_w1c = 0;
    chk("R12 clear", {31'd0, err_pending}, 32'd0);
    en_lec = 0;
    ev(0, 0, 3'd4);
    chk("R11 code disabled", {31'd0, err_pending}, 32'd0);
    en_warn = 1;
    for (int i = 0; i < 11; i++) ev(1, 0, 3'd4);
    chk("R11 below warn", {31'd0, err_pending}, 32'd0);
    ev(1, 0, 3'd4);
    chk("R10 warn cause", {31'd0, err_pending}, 32'd1);
    en_lec = 1; pend_w1c = 1;
    ev(0, 0, 3'd1);
    pend_w1c = 0;
    chk("R12 set wins", {31'd0, err_pending}, 32'd1);
    en_glob = 0; pend_w1c = 1; @(negedge clk); pend_w1c = 0;
    ev(1, 0, 3'd5);
    chk("R11 glob off", {31'd0, err_pending}, 32'd0);
    en_lec = 0; en_warn = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_counts();
    t_flags();
    t_lec_sw();
    t_irq();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule